// File: doc/BRIEF.md
# Shared Queue RAM with Two-Port Arbiter

This block is a small shared storage array that a host CPU and a serial-queue engine both use. The CPU side is a simple request/ready port that reads and writes bytes, half-words and words at byte addresses. The engine side names an entry by operation and index. It can fetch a transmit entry, fetch a command byte, or store a receive entry. Both ports reach one 16-bit-wide array, so only one of them is served in each cycle.

The 160-byte address space holds three fixed regions and a reserved tail. Receive entries take bytes 0x00 to 0x1F, as sixteen 16-bit entries with entry i at byte 2i. Transmit entries take bytes 0x20 to 0x3F, laid out the same way. Command bytes take 0x40 to 0x4F, one byte per entry. Everything from 0x50 upward is reserved and holds no storage.

A word access needs two array cycles. When the word is aligned to four bytes, the two halves run back to back and the engine is locked out between them. When the word is two-byte aligned only, the two halves are arbitrated separately, so the engine can update the array between them. The engine wins a tie, but the CPU never waits more than two cycles for any one half.

Top module: `shared_qram`

## Requirements
- R1: After reset every stored byte reads as zero. With no request on either port, `cpu_rdy` and `eng_gnt` are both low.
- R2: Receive entry i is at CPU byte address 2i, transmit entry i at 0x20+2i, and command byte i at 0x40+i. CPU addresses 0x50 and above read as zero, and CPU writes to them are dropped.
- R3: Byte order is little-endian. A byte read returns the addressed byte in `cpu_rdata[7:0]`, zero-extended. A half-word access ignores `cpu_addr[0]` and uses bits [15:0]. A word access ignores `cpu_addr[0]` and puts the lower-addressed half in bits [15:0].
- R4: A CPU byte write changes only the addressed byte. The other byte of the same 16-bit entry keeps its value.
- R5: `eng_op` selects the engine operation:
  - 0 reads transmit entry `eng_idx` into `eng_rdata`.
  - 1 reads command byte `eng_idx` into `eng_rdata[7:0]`, zero-extended.
  - 2 writes `eng_wdata` to receive entry `eng_idx`.
  - 3 is never granted.
- R6: When both ports request, no lock is held and the CPU has waited fewer than two cycles in its current half, the engine is granted and `cpu_rdy` stays low.
- R7: Each half of a CPU access is served after at most two wait cycles, even if the engine requests in every cycle.
- R8: A word at an address with `cpu_addr[1]`=0 runs its two halves in consecutive cycles. The engine is not granted in the second cycle, even when it requests.
- R9: A word at an address with `cpu_addr[1]`=1 arbitrates each half on its own. An engine write granted between the halves is seen in the result of the second half.
- R10: `cpu_rdy` is high only while `cpu_req` is high. It rises in the first cycle for an uncontested byte or half-word, and in the second cycle for an uncontested word. `cpu_rdata` is valid in the cycle `cpu_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request; held with its fields until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rdy | output | 1 | Access completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_rdy` |
| eng_req | input | 1 | Engine request |
| eng_op | input | 2 | Engine operation (see R5) |
| eng_idx | input | 4 | Entry index |
| eng_wdata | input | 16 | Receive entry data |
| eng_gnt | output | 1 | Engine operation performed in this cycle |
| eng_rdata | output | 16 | Engine read data, valid with `eng_gnt` |

## Verification
A wrong sequencer state shows at the ports within one access.
- A stuck half-flag makes a word finish a cycle early or late, or come back with the halves swapped. The ready count and the read value expose this on the first word read.
- A broken lock lets the engine be granted in the second cycle of an aligned word.
- A broken wait counter either starves the CPU, which is caught on the third stalled cycle, or ignores the engine tie-break, which makes `cpu_rdy` rise in the first contested cycle.
- Region or byte-lane decode errors show on the next engine fetch of an entry the CPU wrote.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } cpu_size_e;

  typedef enum logic [1:0] {
    EOP_TX_RD  = 2'd0,
    EOP_CMD_RD = 2'd1,
    EOP_RX_WR  = 2'd2,
    EOP_NONE   = 2'd3
  } eng_op_e;
endpackage

// File: rtl/sqr_store.sv
module sqr_store #(
  parameter int LIVE_HW = 40,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] hw_addr,
  input  logic [1:0]    be,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  logic [15:0] cells [LIVE_HW];
  logic        hit;
  logic [1:0]  lane_we;

  assign hit = (hw_addr < AW'(LIVE_HW));

  for (genvar gl = 0; gl < 2; gl++) begin : g_lane
    assign lane_we[gl] = wr_en & hit & be[gl];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LIVE_HW; i++) cells[i] <= '0;
    end else begin
      for (int i = 0; i < LIVE_HW; i++) begin
        for (int l = 0; l < 2; l++) begin
          if (lane_we[l] && hw_addr == AW'(i)) cells[i][l*8 +: 8] <= wdata[l*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < LIVE_HW; i++) begin
      if (hit && hw_addr == AW'(i)) rdata = cells[i];
    end
  end
endmodule

// File: rtl/sqr_eng_map.sv
module sqr_eng_map
  import sqr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int IDX_W    = 4,
  parameter int TX_BASE  = 32,
  parameter int CMD_BASE = 64
) (
  input  logic             eng_req,
  input  logic [1:0]       eng_op,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [15:0]      store_rdata,
  output logic             eng_valid,
  output logic             eng_write,
  output logic [AW-1:0]    eng_hw,
  output logic [15:0]      eng_rdata
);
  localparam int TX_HW = TX_BASE / 2;
  logic [AW-1:0] cmd_byte;
  eng_op_e       op;

  assign op        = eng_op_e'(eng_op);
  assign cmd_byte  = AW'(CMD_BASE) + AW'(eng_idx);
  assign eng_valid = eng_req & (op != EOP_NONE);
  assign eng_write = (op == EOP_RX_WR);

  always_comb begin
    unique case (op)
      EOP_TX_RD:  eng_hw = AW'(TX_HW) + AW'(eng_idx);
      EOP_CMD_RD: eng_hw = cmd_byte >> 1;
      EOP_RX_WR:  eng_hw = AW'(eng_idx);
      default:    eng_hw = '0;
    endcase
  end

  always_comb begin
    if (op == EOP_CMD_RD)
      eng_rdata = {8'h00, cmd_byte[0] ? store_rdata[15:8] : store_rdata[7:0]};
    else
      eng_rdata = store_rdata;
  end
endmodule

// File: rtl/sqr_cpu_seq.sv
module sqr_cpu_seq
  import sqr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int MAX_WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_size,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  input  logic          eng_valid,
  input  logic [15:0]   store_rdata,
  output logic          cpu_go,
  output logic          cpu_rdy,
  output logic [31:0]   cpu_rdata,
  output logic          eng_gnt,
  output logic [AW-1:0] cpu_hw,
  output logic [1:0]    cpu_be,
  output logic [15:0]   cpu_wd16
);
  localparam int WW = $clog2(MAX_WAIT + 1);

  logic          part_q, part_d;
  logic          lock_q, lock_d;
  logic [WW-1:0] wait_q, wait_d;
  logic [15:0]   low_q, low_d;
  logic          live_q;
  logic          is_word, is_byte, aligned;
  cpu_size_e     sz;

  assign sz      = cpu_size_e'(cpu_size);
  assign is_word = cpu_size[1];
  assign is_byte = (sz == SZ_BYTE);
  assign aligned = is_word & ~cpu_addr[1];

  // arbitration
  assign cpu_go  = cpu_req & (lock_q | ~eng_valid | (wait_q == WW'(MAX_WAIT)));
  assign eng_gnt = eng_valid & ~cpu_go & ~lock_q;
  assign cpu_rdy = cpu_go & (~is_word | part_q);

  // access formatting
  assign cpu_hw = (cpu_addr >> 1) + AW'(part_q);

  always_comb begin
    if (is_byte) begin
      cpu_be   = cpu_addr[0] ? 2'b10 : 2'b01;
      cpu_wd16 = {cpu_wdata[7:0], cpu_wdata[7:0]};
    end else begin
      cpu_be   = 2'b11;
      cpu_wd16 = (is_word && part_q) ? cpu_wdata[31:16] : cpu_wdata[15:0];
    end
  end

  always_comb begin
    if (is_byte)
      cpu_rdata = {24'h0, cpu_addr[0] ? store_rdata[15:8] : store_rdata[7:0]};
    else if (!is_word)
      cpu_rdata = {16'h0, store_rdata};
    else
      cpu_rdata = {store_rdata, low_q};
  end

  // next state
  always_comb begin
    part_d = part_q;
    lock_d = lock_q;
    low_d  = low_q;
    wait_d = wait_q;
    if (!cpu_req || cpu_go) wait_d = '0;
    else if (wait_q != WW'(MAX_WAIT)) wait_d = wait_q + 1'b1;
    if (!cpu_req) begin
      part_d = 1'b0;
      lock_d = 1'b0;
    end else if (cpu_go && is_word && !part_q) begin
      part_d = 1'b1;
      lock_d = aligned;
      low_d  = store_rdata;
    end else if (cpu_go && part_q) begin
      part_d = 1'b0;
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= 1'b0;
      lock_q <= 1'b0;
      wait_q <= '0;
      low_q  <= '0;
      live_q <= 1'b0;
    end else begin
      part_q <= part_d;
      lock_q <= lock_d;
      wait_q <= wait_d;
      live_q <= 1'b1;
      if (cpu_go && is_word && !part_q) low_q <= low_d;
    end
  end

  // R8: the cycle after the first half of an aligned word never grants the engine
  a_r8_aligned_locks_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $past(live_q && cpu_go && aligned && !part_q) |-> !eng_gnt);

  // R8: second half of an aligned word is served in the very next cycle
  a_r8_second_half_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(live_q && cpu_go && aligned && !part_q) && cpu_req) |-> cpu_rdy);
endmodule

// File: rtl/shared_qram.sv
module shared_qram
  import sqr_pkg::*;
#(
  parameter int RX_ENTRIES  = 16,
  parameter int TX_ENTRIES  = 16,
  parameter int CMD_BYTES   = 16,
  parameter int TOTAL_BYTES = 160,
  parameter int MAX_WAIT    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic [7:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_rdy,
  output logic [31:0] cpu_rdata,
  input  logic        eng_req,
  input  logic [1:0]  eng_op,
  input  logic [3:0]  eng_idx,
  input  logic [15:0] eng_wdata,
  output logic        eng_gnt,
  output logic [15:0] eng_rdata
);
  localparam int AW       = 8;
  localparam int IDX_W    = 4;
  localparam int TX_BASE  = 2 * RX_ENTRIES;
  localparam int CMD_BASE = TX_BASE + 2 * TX_ENTRIES;
  localparam int RSV_BASE = CMD_BASE + CMD_BYTES;
  localparam int LIVE_HW  = RSV_BASE / 2;
  localparam int HW_CNT   = $clog2(MAX_WAIT + 2);

  logic          eng_valid, eng_write, cpu_go;
  logic [AW-1:0] eng_hw, cpu_hw, st_hw;
  logic [1:0]    cpu_be, st_be;
  logic [15:0]   cpu_wd16, st_wd, st_rd;
  logic          st_we;

  sqr_eng_map #(.AW(AW), .IDX_W(IDX_W), .TX_BASE(TX_BASE), .CMD_BASE(CMD_BASE)) u_map (
    .eng_req(eng_req), .eng_op(eng_op), .eng_idx(eng_idx), .store_rdata(st_rd),
    .eng_valid(eng_valid), .eng_write(eng_write), .eng_hw(eng_hw), .eng_rdata(eng_rdata)
  );

  sqr_cpu_seq #(.AW(AW), .MAX_WAIT(MAX_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .eng_valid(eng_valid), .store_rdata(st_rd), .cpu_go(cpu_go),
    .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .eng_gnt(eng_gnt), .cpu_hw(cpu_hw),
    .cpu_be(cpu_be), .cpu_wd16(cpu_wd16)
  );

  // port mux into the single array port
  always_comb begin
    if (eng_gnt) begin
      st_hw = eng_hw;
      st_be = 2'b11;
      st_wd = eng_wdata;
      st_we = eng_write;
    end else begin
      st_hw = cpu_hw;
      st_be = cpu_be;
      st_wd = cpu_wd16;
      st_we = cpu_go & cpu_we;
    end
  end

  sqr_store #(.LIVE_HW(LIVE_HW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(st_we), .hw_addr(st_hw), .be(st_be),
    .wdata(st_wd), .rdata(st_rd)
  );

  // checker: consecutive cycles the CPU waits while the engine is served
  logic [HW_CNT-1:0] starve_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) starve_q <= '0;
    else if (cpu_req && eng_gnt) starve_q <= starve_q + 1'b1;
    else starve_q <= '0;
  end

  // R7: the engine never takes a third consecutive cycle from a waiting CPU
  a_r7_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (starve_q == HW_CNT'(MAX_WAIT)) |-> !(cpu_req && eng_gnt));

  // R5: the idle engine code is never granted
  a_r5_op_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op == 2'd3) |-> !eng_gnt);

  // R6: a valid engine request only loses to a pending CPU request
  a_r6_engine_loses_only_to_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op != 2'd3 && !eng_gnt) |-> cpu_req);

  // R10: ready only answers a live request, and the ports are never served together
  a_r10_rdy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |-> (cpu_req && !eng_gnt));
endmodule

// File: tb/shared_qram_bench.sv
module shared_qram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [1:0]  cpu_size;
  logic [7:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_rdy;
  logic        eng_req;
  logic [1:0]  eng_op;
  logic [3:0]  eng_idx;
  logic [15:0] eng_wdata, eng_rdata;
  logic        eng_gnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  shared_qram u_shared_qram (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
    .eng_req(eng_req), .eng_op(eng_op), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .eng_gnt(eng_gnt), .eng_rdata(eng_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // starts right after a falling edge; returns cycles to ready and engine grants seen
  task automatic cpu_do(input bit we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int cyc, output int gnts);
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; gnts = 0; rd = '0;
    for (int k = 0; k < 20; k++) begin
      cyc++;
      #1;
      if (eng_gnt) gnts++;
      if (cpu_rdy) begin
        rd = cpu_rdata;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic eng_do(input logic [1:0] op, input logic [3:0] idx,
                        input logic [15:0] wd, output logic [15:0] rd, output bit g);
    eng_req = 1'b1; eng_op = op; eng_idx = idx; eng_wdata = wd;
    #1;
    g = eng_gnt; rd = eng_rdata;
    @(negedge clk);
    eng_req = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] r; bit g;
    check(!cpu_rdy && !eng_gnt, "R1 idle outputs", {cpu_rdy, eng_gnt}, 0);
    eng_do(2'd0, 4'd0, 16'h0, r, g);
    check(g && r == 16'h0, "R1 transmit entry zero", r, 0);
    eng_do(2'd1, 4'd15, 16'h0, r, g);
    check(g && r == 16'h0, "R1 command byte zero", r, 0);
  endtask

  task automatic t_map_endian;
    logic [31:0] d; logic [15:0] r; bit g; int c, n;
    cpu_do(1'b1, 2'd2, 8'h20, 32'h1234_5678, d, c, n);
    eng_do(2'd0, 4'd0, 16'h0, r, g);
    check(r == 16'h5678, "R2 R3 tx0 low half", r, 16'h5678);
    eng_do(2'd0, 4'd1, 16'h0, r, g);
    check(r == 16'h1234, "R2 R3 tx1 high half", r, 16'h1234);
    cpu_do(1'b1, 2'd0, 8'h21, 32'h0000_00AB, d, c, n);
    eng_do(2'd0, 4'd0, 16'h0, r, g);
    check(r == 16'hAB78, "R4 byte lane write", r, 16'hAB78);
    cpu_do(1'b0, 2'd0, 8'h22, 32'h0, d, c, n);
    check(d == 32'h34, "R3 byte read zero-extended", d, 32'h34);
    cpu_do(1'b0, 2'd1, 8'h21, 32'h0, d, c, n);
    check(d == 32'hAB78, "R3 half ignores addr0", d, 32'hAB78);
  endtask

  task automatic t_engine_ops;
    logic [31:0] d; logic [15:0] r; bit g; int c, n;
    cpu_do(1'b1, 2'd0, 8'h45, 32'h5C, d, c, n);
    eng_do(2'd1, 4'd5, 16'h0, r, g);
    check(g && r == 16'h005C, "R5 command byte read", r, 16'h005C);
    eng_do(2'd2, 4'd3, 16'hBEEF, r, g);
    check(g, "R5 receive write granted", g, 1);
    cpu_do(1'b0, 2'd1, 8'h06, 32'h0, d, c, n);
    check(d == 32'hBEEF, "R5 R2 receive entry 3", d, 32'hBEEF);
    eng_do(2'd3, 4'd0, 16'h0, r, g);
    check(!g, "R5 op 3 never granted", g, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d; int c, n;
    cpu_do(1'b1, 2'd2, 8'h50, 32'hDEAD_BEEF, d, c, n);
    cpu_do(1'b0, 2'd2, 8'h50, 32'h0, d, c, n);
    check(d == 32'h0, "R2 reserved write dropped", d, 0);
    cpu_do(1'b0, 2'd0, 8'h4F, 32'h0, d, c, n);
    check(d == 32'h0, "R2 last command byte untouched", d, 0);
  endtask

  task automatic t_latency;
    logic [31:0] d; int c, n;
    cpu_do(1'b0, 2'd0, 8'h20, 32'h0, d, c, n);
    check(c == 1, "R10 byte latency", c, 1);
    cpu_do(1'b0, 2'd2, 8'h20, 32'h0, d, c, n);
    check(c == 2 && d == 32'h1234_AB78, "R10 word latency", c, 2);
  endtask

  task automatic t_contention;
    logic [31:0] d; int c, n;
    eng_req = 1'b1; eng_op = 2'd0; eng_idx = 4'd0;
    cpu_do(1'b0, 2'd0, 8'h20, 32'h0, d, c, n);
    check(c == 3, "R6 R7 byte waits two cycles", c, 3);
    check(n == 2, "R6 engine served twice", n, 2);
    cpu_do(1'b0, 2'd2, 8'h20, 32'h0, d, c, n);
    check(c == 4 && n == 2, "R8 aligned word under load", c, 4);
    check(d == 32'h1234_AB78, "R8 aligned word data", d, 32'h1234_AB78);
    cpu_do(1'b0, 2'd2, 8'h22, 32'h0, d, c, n);
    check(c == 6 && n == 4, "R9 R7 split word under load", c, 6);
    eng_req = 1'b0;
  endtask

  task automatic t_lock_timing;
    logic [31:0] d; logic [15:0] r; bit g; int c, n;
    cpu_do(1'b1, 2'd2, 8'h00, 32'h1111_0000, d, c, n);
    cpu_do(1'b1, 2'd2, 8'h04, 32'h0000_2222, d, c, n);
    // aligned word; engine arrives for the second half
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'd2; cpu_addr = 8'h00;
    #1;
    check(!cpu_rdy, "R8 first half not ready", cpu_rdy, 0);
    @(negedge clk);
    eng_req = 1'b1; eng_op = 2'd2; eng_idx = 4'd1; eng_wdata = 16'h9999;
    #1;
    check(cpu_rdy && !eng_gnt, "R8 engine locked out", {cpu_rdy, eng_gnt}, 2'b10);
    check(cpu_rdata == 32'h1111_0000, "R8 atomic word data", cpu_rdata, 32'h1111_0000);
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    check(eng_gnt, "R8 engine served after lock", eng_gnt, 1);
    @(negedge clk);
    eng_req = 1'b0;
    // split word; engine slips in between halves
    cpu_req = 1'b1; cpu_addr = 8'h02;
    #1;
    check(!cpu_rdy, "R9 first half not ready", cpu_rdy, 0);
    @(negedge clk);
    eng_req = 1'b1; eng_op = 2'd2; eng_idx = 4'd2; eng_wdata = 16'h7777;
    #1;
    check(eng_gnt && !cpu_rdy, "R9 engine between halves", {cpu_rdy, eng_gnt}, 2'b01);
    @(negedge clk);
    eng_req = 1'b0;
    #1;
    check(cpu_rdy && cpu_rdata == 32'h7777_9999, "R9 second half sees engine write",
          cpu_rdata, 32'h7777_9999);
    @(negedge clk);
    cpu_req = 1'b0;
    eng_do(2'd0, 4'd0, 16'h0, r, g);
  endtask

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'd0; cpu_addr = '0;
    cpu_wdata = '0; eng_req = 1'b0; eng_op = 2'd0; eng_idx = '0; eng_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map_endian();
    t_engine_ops();
    t_reserved();
    t_latency();
    t_contention();
    t_lock_timing();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule